// File: doc/BRIEF.md
# PCI Configuration Access Router

This block sits behind a host bridge's configuration window. Software first stores a configuration-address word, then issues configuration-data reads and writes of 1, 2 or 4 bytes. The router takes the stored word apart: bus number, device number, function number and a dword-aligned register offset. It then decides where each data access goes. Device 0, function 0 is the bridge itself, and its 256-byte configuration header lives inside the router as a byte array with fixed reset contents. Any other device number is sent out on a request/acknowledge port to a downstream device slot, but only when a device has been registered at that slot.

Several cases never reach a target and are answered locally in one cycle: a nonzero bus number, an illegal access size, and an empty slot. Reads in these cases return zero and writes are dropped. An illegal size and an empty slot each raise their own error flag alongside the response. Multi-byte accesses to the bridge's own header use big-endian packing, so the byte at the lowest address carries the most significant bits of the data word. Downstream devices are registered through a small port. The router refuses to register a slot that is already taken, and it treats slot 0 as permanently held by the bridge.

Top module: `cfg_access_router`

## Requirements
- R1: The stored address word is decoded as follows. Bus number is bits 15:8. Device number is bits 23:19. Function number is bits 18:16. Register offset is bits 31:24 with bits 25:24 treated as zero, so an offset byte of 0xAF addresses 0xAC.
- R2: When the bus number is nonzero, a read returns 0 and a write changes nothing. Neither raises an error flag. The response pulse `rsp_valid` appears one clock after the request is accepted.
- R3: Reads from the bridge header place the byte at the offset in the most significant position. A size-1 read returns {24'b0,b[off]}. A size-2 read returns {16'b0,b[off],b[off+1]}. A size-4 read returns {b[off],b[off+1],b[off+2],b[off+3]}.
- R4: Writes to the bridge header scatter the value the same way. A size-4 write stores wdata[31:24] at the offset and wdata[7:0] at offset+3. A size-2 write stores wdata[15:8] and wdata[7:0] at offset and offset+1. A size-1 write stores wdata[7:0] at the offset.
- R5: After reset, header bytes 0x06 and 0x07 hold 0x80 and 0x00. Byte 0x08 holds 0x40, byte 0x09 holds 0x00, byte 0x0A holds 0x00 and byte 0x0B holds 0x06. Byte 0x73 holds 0xCD. Bytes 0xA8..0xAB hold 10 00 00 FF, and bytes 0xAC..0xAF hold 0C 06 0C 00. Every other byte is 0.
- R6: The size field `data_size` carries the byte count, and only 1, 2 and 4 are legal. Any other value, on bus 0, makes a read return 0 and a write store nothing, and `err_size` pulses together with `rsp_valid`.
- R7: An access on bus 0 with a legal size to a slot with no registered device returns 0 on a read and is dropped on a write. `err_absent` pulses together with `rsp_valid`. This case includes device 0 with a nonzero function and any device number at or above NSLOTS.
- R8: An access to a registered slot does the following. It raises the one-hot bit `dn_req[slot]` and holds it. At the same time it presents the offset, function, size, write flag and write data. `data_ready` stays low until that slot pulses `dn_ack`. `rsp_valid` follows one clock after the acknowledge, carrying `dn_rdata` for a read and 0 for a write.
- R9: Registration works as follows. A registration request to a free slot below NSLOTS sets that slot's `slot_present` bit. A request to an occupied slot, to slot 0 or to a slot at or above NSLOTS is refused. `reg_refused` pulses one clock later and `slot_present` is left unchanged.
- R10: The address register resets to 0, so a data access issued before any address write targets the bridge header at offset 0.
- R11: Bridge header writes have no read-only protection. Every byte written, including the class and revision bytes, reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr_en | input | 1 | Store `addr_wr_data` as the configuration-address word |
| addr_wr_data | input | 32 | Configuration-address word |
| data_req | input | 1 | Configuration-data access request, accepted while `data_ready` is high |
| data_we | input | 1 | 1 = write, 0 = read |
| data_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| data_wdata | input | 32 | Write data, right-aligned |
| data_ready | output | 1 | Router idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_valid` |
| err_size | output | 1 | Illegal size, valid with `rsp_valid` |
| err_absent | output | 1 | Empty slot, valid with `rsp_valid` |
| reg_en | input | 1 | Register a device at `reg_slot` |
| reg_slot | input | 5 | Slot number to register |
| reg_refused | output | 1 | Pulse: the previous registration was refused |
| slot_present | output | NSLOTS | Occupied-slot mask, bit 0 always set |
| dn_req | output | NSLOTS | One-hot request toward a downstream slot |
| dn_we | output | 1 | Forwarded write flag |
| dn_func | output | 3 | Forwarded function number |
| dn_offset | output | 8 | Forwarded dword-aligned offset |
| dn_size | output | 3 | Forwarded access size |
| dn_wdata | output | 32 | Forwarded write data |
| dn_ack | input | NSLOTS | One-cycle acknowledge per slot |
| dn_rdata | input | 32 | Read data, valid with the acknowledge |

## Verification
Header reads are walked across all three sizes at offsets that hold distinctive defaults. This separates correct byte order and width masking from swapped or truncated packing, and an unaligned offset byte confirms that the low offset bits are dropped. Writes of each size followed by full-word reads expose scatter errors and any hidden write protection. Each pattern that never reaches a target is aimed at the same bytes and followed by a readback: nonzero bus, illegal size, empty slot, and device 0 with a nonzero function. This shows that the patterns differ only in their error flags and that none of them stores anything. Forwarded reads and writes are checked on the downstream port while the host is held off, and repeated registration of the same slot shows that a refusal leaves the mask unchanged.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

   localparam int unsigned OFF_W     = 8;
   localparam int unsigned HDR_BYTES = 1 << OFF_W;
   localparam int unsigned DEV_W     = 5;
   localparam int unsigned FUNC_W    = 3;
   localparam int unsigned WORD_W    = 32;

   typedef enum logic [1:0] {
      TGT_SELF     = 2'd0,
      TGT_FWD      = 2'd1,
      TGT_ABSENT   = 2'd2,
      TGT_OTHERBUS = 2'd3
   } tgt_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } rtr_state_e;

   // legal access widths in bytes
   function automatic logic size_legal(input logic [2:0] sz);
      return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
   endfunction

   // power-on contents of the bridge header
   function automatic logic [7:0] hdr_default(input int unsigned idx);
      case (idx)
         32'h06:  return 8'h80;
         32'h08:  return 8'h40;
         32'h0B:  return 8'h06;
         32'h73:  return 8'hCD;
         32'hA8:  return 8'h10;
         32'hAB:  return 8'hFF;
         32'hAC:  return 8'h0C;
         32'hAD:  return 8'h06;
         32'hAE:  return 8'h0C;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
   import cfg_router_pkg::*;
#(
   parameter int unsigned NSLOTS = 32
) (
   input  logic [WORD_W-1:0] cfg_word,
   input  logic [NSLOTS-1:0] present,
   output logic [DEV_W-1:0]  dev,
   output logic [FUNC_W-1:0] func,
   output logic [OFF_W-1:0]  off,
   output tgt_e              tgt
);

   localparam int unsigned MAX_SLOTS = 1 << DEV_W;

   if (NSLOTS < 2 || NSLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("cfg_addr_decode: NSLOTS out of range");
   end

   logic       bus_nz;
   logic       slot_hit;
   logic [MAX_SLOTS-1:0] pres_full;

   assign bus_nz = |cfg_word[15:8];
   assign dev    = cfg_word[23:19];
   assign func   = cfg_word[18:16];
   assign off    = {cfg_word[31:26], 2'b00};

   if (NSLOTS == MAX_SLOTS) begin : g_full_map
      assign pres_full = present;
   end else begin : g_part_map
      assign pres_full = {{(MAX_SLOTS - NSLOTS){1'b0}}, present};
   end

   assign slot_hit = pres_full[dev];

   always_comb begin
      if (bus_nz) begin
         tgt = TGT_OTHERBUS;
      end else if (dev == '0 && func == '0) begin
         tgt = TGT_SELF;
      end else if (dev != '0 && slot_hit) begin
         tgt = TGT_FWD;
      end else begin
         tgt = TGT_ABSENT;
      end
   end

endmodule

// File: rtl/cfg_self_space.sv
module cfg_self_space
   import cfg_router_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  off,
   input  logic [2:0]        size,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);

   localparam int unsigned FLAT_W = HDR_BYTES * 8;
   localparam int unsigned ROW_W  = OFF_W - 2;

   logic [FLAT_W-1:0] flat;
   logic [ROW_W-1:0]  row;

   assign row = off[OFF_W-1:2];

   for (genvar gi = 0; gi < HDR_BYTES; gi++) begin : g_byte
      localparam logic [ROW_W-1:0] MY_ROW  = ROW_W'(gi >> 2);
      localparam logic [1:0]       MY_LANE = 2'(gi & 3);
      localparam logic [7:0]       RST_VAL = hdr_default(gi);

      logic [7:0]        b_q;
      logic              b_we;
      logic [1:0]        sh_amt;
      logic [WORD_W-1:0] shifted;

      // lane k of an n-byte write takes byte (n-1-k) of the data word
      assign sh_amt  = 2'(size - 3'd1 - {1'b0, MY_LANE});
      assign shifted = wdata >> {sh_amt, 3'b000};
      assign b_we    = wr_en && (row == MY_ROW) && ({1'b0, MY_LANE} < size);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            b_q <= RST_VAL;
         end else if (b_we) begin
            b_q <= shifted[7:0];
         end
      end

      assign flat[gi*8 +: 8] = b_q;
   end

   logic [7:0] rb [4];

   for (genvar gk = 0; gk < 4; gk++) begin : g_rd
      logic [OFF_W-1:0] idx;
      assign idx    = {row, 2'(gk)};
      assign rb[gk] = flat[{idx, 3'b000} +: 8];
   end

   always_comb begin
      case (size)
         3'd1:    rdata = {24'h0, rb[0]};
         3'd2:    rdata = {16'h0, rb[0], rb[1]};
         3'd4:    rdata = {rb[0], rb[1], rb[2], rb[3]};
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/cfg_slot_registry.sv
module cfg_slot_registry
   import cfg_router_pkg::*;
#(
   parameter int unsigned NSLOTS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_en,
   input  logic [DEV_W-1:0]  reg_slot,
   output logic [NSLOTS-1:0] present,
   output logic              refused
);

   logic occupied;

   always_comb begin
      occupied = 1'b1;
      for (int k = 0; k < NSLOTS; k++) begin
         if (reg_slot == DEV_W'(k)) occupied = present[k];
      end
   end

   for (genvar gs = 0; gs < NSLOTS; gs++) begin : g_slot
      if (gs == 0) begin : g_bridge
         assign present[gs] = 1'b1;
      end else begin : g_dev
         logic p_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               p_q <= 1'b0;
            end else if (reg_en && reg_slot == DEV_W'(gs) && !p_q) begin
               p_q <= 1'b1;
            end
         end
         assign present[gs] = p_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) refused <= 1'b0;
      else        refused <= reg_en && occupied;
   end

endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
   import cfg_router_pkg::*;
#(
   parameter int unsigned NSLOTS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_wr_en,
   input  logic [31:0]       addr_wr_data,
   input  logic              data_req,
   input  logic              data_we,
   input  logic [2:0]        data_size,
   input  logic [31:0]       data_wdata,
   output logic              data_ready,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              err_size,
   output logic              err_absent,
   input  logic              reg_en,
   input  logic [4:0]        reg_slot,
   output logic              reg_refused,
   output logic [NSLOTS-1:0] slot_present,
   output logic [NSLOTS-1:0] dn_req,
   output logic              dn_we,
   output logic [2:0]        dn_func,
   output logic [7:0]        dn_offset,
   output logic [2:0]        dn_size,
   output logic [31:0]       dn_wdata,
   input  logic [NSLOTS-1:0] dn_ack,
   input  logic [31:0]       dn_rdata
);

   logic [WORD_W-1:0] cfg_q;
   rtr_state_e        state_q;

   logic [DEV_W-1:0]  dec_dev;
   logic [FUNC_W-1:0] dec_func;
   logic [OFF_W-1:0]  dec_off;
   tgt_e              dec_tgt;
   logic [WORD_W-1:0] self_rdata;
   logic              accept;
   logic              sz_ok;
   logic              self_wr;
   logic              ack_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)          cfg_q <= '0;
      else if (addr_wr_en) cfg_q <= addr_wr_data;
   end

   cfg_addr_decode #(.NSLOTS(NSLOTS)) u_decode (
      .cfg_word (cfg_q),
      .present  (slot_present),
      .dev      (dec_dev),
      .func     (dec_func),
      .off      (dec_off),
      .tgt      (dec_tgt)
   );

   cfg_slot_registry #(.NSLOTS(NSLOTS)) u_registry (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_en   (reg_en),
      .reg_slot (reg_slot),
      .present  (slot_present),
      .refused  (reg_refused)
   );

   assign data_ready = (state_q == ST_IDLE);
   assign accept     = data_req && data_ready;
   assign sz_ok      = size_legal(data_size);
   assign self_wr    = accept && data_we && sz_ok && (dec_tgt == TGT_SELF);
   assign ack_hit    = |(dn_ack & dn_req);

   cfg_self_space u_self (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (self_wr),
      .off   (dec_off),
      .size  (data_size),
      .wdata (data_wdata),
      .rdata (self_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         err_size   <= 1'b0;
         err_absent <= 1'b0;
         dn_req     <= '0;
         dn_we      <= 1'b0;
         dn_func    <= '0;
         dn_offset  <= '0;
         dn_size    <= '0;
         dn_wdata   <= '0;
      end else begin
         rsp_valid  <= 1'b0;
         err_size   <= 1'b0;
         err_absent <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (dec_tgt == TGT_OTHERBUS) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= '0;
                  end else if (!sz_ok) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= '0;
                     err_size  <= 1'b1;
                  end else begin
                     case (dec_tgt)
                        TGT_SELF: begin
                           rsp_valid <= 1'b1;
                           rsp_rdata <= data_we ? '0 : self_rdata;
                        end
                        TGT_FWD: begin
                           state_q   <= ST_BUSY;
                           dn_req    <= NSLOTS'(1) << dec_dev;
                           dn_we     <= data_we;
                           dn_func   <= dec_func;
                           dn_offset <= dec_off;
                           dn_size   <= data_size;
                           dn_wdata  <= data_wdata;
                        end
                        default: begin
                           rsp_valid  <= 1'b1;
                           rsp_rdata  <= '0;
                           err_absent <= 1'b1;
                        end
                     endcase
                  end
               end
            end
            ST_BUSY: begin
               if (ack_hit) begin
                  state_q   <= ST_IDLE;
                  dn_req    <= '0;
                  rsp_valid <= 1'b1;
                  rsp_rdata <= dn_we ? '0 : dn_rdata;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cfg_access_router_chk.sv
module cfg_access_router_chk #(
   parameter int unsigned NSLOTS = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              data_ready,
   input logic              rsp_valid,
   input logic [31:0]       rsp_rdata,
   input logic              err_size,
   input logic              err_absent,
   input logic              reg_refused,
   input logic [NSLOTS-1:0] slot_present,
   input logic [NSLOTS-1:0] dn_req,
   input logic [NSLOTS-1:0] dn_ack
);

   // R8: host held off while a downstream request is open
   p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|dn_req) |-> !data_ready);

   // R8: at most one slot addressed
   p_req_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dn_req));

   // R8: request held until its slot acknowledges
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|dn_req) && !(|(dn_ack & dn_req))) |=> (dn_req == $past(dn_req)));

   // R8: completion follows the acknowledge by one clock
   p_rsp_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(dn_ack & dn_req)) |=> rsp_valid);

   // R6 R7: error flags only with a response, never both
   p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_size || err_absent) |-> (rsp_valid && !(err_size && err_absent)));

   // R7: an empty-slot read returns zero
   p_absent_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && err_absent) |-> (rsp_rdata == 32'h0));

   // R9: bridge slot always occupied, refusal leaves mask alone
   p_bridge_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      slot_present[0]);

   p_refuse_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_refused |-> $stable(slot_present));

endmodule

bind cfg_access_router cfg_access_router_chk #(.NSLOTS(NSLOTS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .data_ready   (data_ready),
   .rsp_valid    (rsp_valid),
   .rsp_rdata    (rsp_rdata),
   .err_size     (err_size),
   .err_absent   (err_absent),
   .reg_refused  (reg_refused),
   .slot_present (slot_present),
   .dn_req       (dn_req),
   .dn_ack       (dn_ack)
);

// File: tb/cfg_access_router_tb.sv
`timescale 1ns/1ps
module cfg_access_router_tb;

   localparam int unsigned NS = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          addr_wr_en = 1'b0;
   logic [31:0]   addr_wr_data = '0;
   logic          data_req = 1'b0;
   logic          data_we = 1'b0;
   logic [2:0]    data_size = 3'd4;
   logic [31:0]   data_wdata = '0;
   logic          data_ready, rsp_valid, err_size, err_absent, reg_refused;
   logic [31:0]   rsp_rdata;
   logic          reg_en = 1'b0;
   logic [4:0]    reg_slot = '0;
   logic [NS-1:0] slot_present, dn_req;
   logic          dn_we;
   logic [2:0]    dn_func, dn_size;
   logic [7:0]    dn_offset;
   logic [31:0]   dn_wdata;
   logic [NS-1:0] dn_ack = '0;
   logic [31:0]   dn_rdata = '0;

   always #2 clk = ~clk;

   cfg_access_router #(.NSLOTS(NS)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
      .data_req(data_req), .data_we(data_we), .data_size(data_size),
      .data_wdata(data_wdata), .data_ready(data_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .err_size(err_size), .err_absent(err_absent),
      .reg_en(reg_en), .reg_slot(reg_slot), .reg_refused(reg_refused),
      .slot_present(slot_present),
      .dn_req(dn_req), .dn_we(dn_we), .dn_func(dn_func),
      .dn_offset(dn_offset), .dn_size(dn_size), .dn_wdata(dn_wdata),
      .dn_ack(dn_ack), .dn_rdata(dn_rdata)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [7:0] off, input logic [4:0] dev,
                                      input logic [2:0] fn, input logic [7:0] bus);
      return {off, dev, fn, bus, 8'h00};
   endfunction

   // downstream model: acknowledge two clocks after a request appears
   int ack_cnt = 0;
   always @(negedge clk) begin
      if (dn_ack != '0) begin
         dn_ack  = '0;
         ack_cnt = 0;
      end else if (dn_req != '0) begin
         ack_cnt++;
         if (ack_cnt == 2) begin
            dn_ack   = dn_req;
            dn_rdata = {16'hC0DE, dn_offset, 8'h5A};
         end
      end else begin
         ack_cnt = 0;
      end
   end

   logic [31:0] r_rdata;
   logic        r_es, r_ea;
   logic [NS-1:0] s_req;
   logic        s_ready, s_we;
   logic [7:0]  s_off;
   logic [2:0]  s_func, s_size;
   logic [31:0] s_wdata;

   task automatic access(input logic [31:0] a, input logic we, input logic [2:0] sz,
                         input logic [31:0] wd, input bit set_addr);
      int n;
      @(negedge clk);
      if (set_addr) begin
         addr_wr_en   = 1'b1;
         addr_wr_data = a;
         @(negedge clk);
         addr_wr_en   = 1'b0;
      end
      n = 0;
      while (!data_ready && n < 50) begin @(negedge clk); n++; end
      data_req   = 1'b1;
      data_we    = we;
      data_size  = sz;
      data_wdata = wd;
      @(negedge clk);
      data_req = 1'b0;
      s_req = dn_req; s_ready = data_ready; s_we = dn_we; s_off = dn_offset;
      s_func = dn_func; s_size = dn_size; s_wdata = dn_wdata;
      n = 0;
      while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
      if (!rsp_valid) chk("response timeout", 32'd0, 32'd1);
      r_rdata = rsp_rdata;
      r_es    = err_size;
      r_ea    = err_absent;
   endtask

   task automatic do_reg(input logic [4:0] s);
      @(negedge clk);
      reg_en   = 1'b1;
      reg_slot = s;
      @(negedge clk);
      reg_en = 1'b0;
   endtask

   // {address word, size, expected read data}
   localparam int NV = 11;
   localparam logic [66:0] VEC [NV] = '{
      {8'h00, 24'h0, 3'd4, 32'h0000_0000},
      {8'h04, 24'h0, 3'd4, 32'h0000_8000},
      {8'h08, 24'h0, 3'd4, 32'h4000_0006},
      {8'h08, 24'h0, 3'd1, 32'h0000_0040},
      {8'h70, 24'h0, 3'd4, 32'h0000_00CD},
      {8'hA8, 24'h0, 3'd4, 32'h1000_00FF},
      {8'hA8, 24'h0, 3'd2, 32'h0000_1000},
      {8'hAC, 24'h0, 3'd4, 32'h0C06_0C00},
      {8'hAC, 24'h0, 3'd1, 32'h0000_000C},
      {8'hAF, 24'h0, 3'd4, 32'h0C06_0C00},
      {8'h40, 24'h0, 3'd2, 32'h0000_0000}
   };

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk("R10 reset data_ready", {31'h0, data_ready}, 32'h1);
      chk("R10 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
      chk("R8 reset dn_req", dn_req, 32'h0);
      chk("R9 reset slot_present", slot_present, 32'h1);
      rst_n = 1'b1;

      // R10: no address write yet -> header offset 0
      access(32'h0, 1'b0, 3'd4, 32'h0, 1'b0);
      chk("R10 read before address write", r_rdata, 32'h0);

      // R3 R5 R1: table walk of header reads
      for (int i = 0; i < NV; i++) begin
         access(VEC[i][66:35], 1'b0, VEC[i][34:32], 32'h0, 1'b1);
         chk($sformatf("R3/R5 vector %0d", i), r_rdata, VEC[i][31:0]);
      end

      // R4 R11: writes of each size, including class/revision bytes
      access(mk(8'h08, 0, 0, 0), 1'b1, 3'd4, 32'hDEADBEEF, 1'b1);
      access(mk(8'h08, 0, 0, 0), 1'b0, 3'd1, 32'h0, 1'b1);
      chk("R4 size-4 write, byte at offset", r_rdata, 32'h0000_00DE);
      access(mk(8'h08, 0, 0, 0), 1'b0, 3'd4, 32'h0, 1'b1);
      chk("R11 class/revision overwritten", r_rdata, 32'hDEADBEEF);
      access(mk(8'h40, 0, 0, 0), 1'b1, 3'd2, 32'hFFFF1234, 1'b1);
      access(mk(8'h40, 0, 0, 0), 1'b0, 3'd4, 32'h0, 1'b1);
      chk("R4 size-2 write", r_rdata, 32'h1234_0000);
      access(mk(8'h44, 0, 0, 0), 1'b1, 3'd1, 32'h000000AB, 1'b1);
      access(mk(8'h44, 0, 0, 0), 1'b0, 3'd4, 32'h0, 1'b1);
      chk("R4 size-1 write", r_rdata, 32'hAB00_0000);

      // R2: nonzero bus
      access(mk(8'hA8, 0, 0, 8'h01), 1'b0, 3'd4, 32'h0, 1'b1);
      chk("R2 other-bus read data", r_rdata, 32'h0);
      chk("R2 other-bus read flags", {30'h0, r_es, r_ea}, 32'h0);
      access(mk(8'h40, 0, 0, 8'h80), 1'b1, 3'd4, 32'hFFFFFFFF, 1'b1);
      access(mk(8'h40, 0, 0, 0), 1'b0, 3'd4, 32'h0, 1'b1);
      chk("R2 other-bus write ignored", r_rdata, 32'h1234_0000);

      // R6: illegal size
      access(mk(8'hA8, 0, 0, 0), 1'b0, 3'd3, 32'h0, 1'b1);
      chk("R6 bad-size read data", r_rdata, 32'h0);
      chk("R6 bad-size flag", {30'h0, r_es, r_ea}, 32'h2);
      access(mk(8'h44, 0, 0, 0), 1'b1, 3'd0, 32'h11223344, 1'b1);
      chk("R6 bad-size write flag", {31'h0, r_es}, 32'h1);
      access(mk(8'h44, 0, 0, 0), 1'b0, 3'd4, 32'h0, 1'b1);
      chk("R6 bad-size write stored nothing", r_rdata, 32'hAB00_0000);

      // R7: empty slots
      access(mk(8'h10, 5'd5, 0, 0), 1'b0, 3'd4, 32'h0, 1'b1);
      chk("R7 absent read data", r_rdata, 32'h0);
      chk("R7 absent read flag", {30'h0, r_es, r_ea}, 32'h1);
      access(mk(8'h10, 5'd5, 0, 0), 1'b1, 3'd4, 32'h55555555, 1'b1);
      chk("R7 absent write flag", {31'h0, r_ea}, 32'h1);
      chk("R7 absent write not forwarded", s_req, 32'h0);
      access(mk(8'h00, 5'd0, 3'd1, 0), 1'b0, 3'd4, 32'h0, 1'b1);
      chk("R7 device 0 function 1 absent", {31'h0, r_ea}, 32'h1);

      // R9: registration
      do_reg(5'd5);
      chk("R9 first registration accepted", {31'h0, reg_refused}, 32'h0);
      chk("R9 mask after registration", slot_present, 32'h0000_0021);
      do_reg(5'd5);
      chk("R9 repeat registration refused", {31'h0, reg_refused}, 32'h1);
      chk("R9 mask unchanged after refusal", slot_present, 32'h0000_0021);
      do_reg(5'd0);
      chk("R9 bridge slot refused", {31'h0, reg_refused}, 32'h1);

      // R8: forwarded read and write
      access(mk(8'h3C, 5'd5, 3'd2, 0), 1'b0, 3'd4, 32'h0, 1'b1);
      chk("R8 fwd read dn_req", s_req, 32'h0000_0020);
      chk("R8 fwd read ready low", {31'h0, s_ready}, 32'h0);
      chk("R8 fwd read fields", {12'h0, s_off, 1'b0, s_func, 1'b0, s_size, 3'b0, s_we},
          {12'h0, 8'h3C, 1'b0, 3'd2, 1'b0, 3'd4, 3'b0, 1'b0});
      chk("R8 fwd read data", r_rdata, 32'hC0DE_3C5A);
      chk("R8 fwd read flags", {30'h0, r_es, r_ea}, 32'h0);
      access(mk(8'h1F, 5'd5, 3'd0, 0), 1'b1, 3'd2, 32'h00007777, 1'b1);
      chk("R8 fwd write strobe", s_req, 32'h0000_0020);
      chk("R8 fwd write data/offset", {s_wdata[23:0], s_off}, {24'h007777, 8'h1C});
      chk("R8 fwd write we", {31'h0, s_we}, 32'h1);
      chk("R8 fwd write rsp data", r_rdata, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule